// File: doc/BRIEF.md
# Test Access Port with Per-Instruction TDO Launch Edge

This block is a serial test access port driven by TCK, TMS, TDI and an active-low asynchronous TRST_n. It contains the sixteen-state TAP controller, a 4-bit instruction register, a one-bit bypass path and a 32-bit identification register. Beyond the usual test instructions it decodes three debug commands. The first sets a sticky request that holds the CPU in reset. The second removes that request. The third fires a one-cycle interrupt request. The instructions that would control boundary scan have no scan cells behind them. They only raise control flags for the surrounding pads.

The feature that sets this port apart is the TDO driver. While a standard instruction is held, TDO and its output enable change on the falling edge of TCK, as standard JTAG timing requires. While one of the debug commands is held, both change on the rising edge instead. Serial data is then ready half a TCK period earlier, which a debug probe can use. The launch edge depends only on the instruction that has been committed to the instruction register. It does not depend on the value being shifted in.

Top module: `tap_dual_edge`

## Requirements
- R1: TRST_n low forces Test-Logic-Reset at once, without a clock. Five TCK cycles with TMS high reach Test-Logic-Reset from any state. TMS low in Test-Logic-Reset moves to Run-Test/Idle.
- R2: Instruction codes: 0000 external test, 0001 sample/preload, 0010 clamp, 0011 high-impedance, 0100 identification, 1000 reset assert, 1001 reset negate, 1010 interrupt, 1111 bypass. Every other code behaves as bypass. Capture-IR loads 0001 into the instruction shifter. Instruction bits enter at TDI and leave at TDO, least significant bit first.
- R3: Test-Logic-Reset and TRST_n select the identification instruction (0100). With that instruction, Capture-DR loads the 32-bit identification word, which is the parameter value with bit 0 forced to 1. The word is shifted out least significant bit first.
- R4: For every instruction other than identification, the data path is a single bypass stage. It captures 0, and TDO repeats TDI one shift cycle later.
- R5: While a standard instruction (any code other than 1000, 1001 and 1010) is held, TDO changes only on the falling edge of TCK.
- R6: While a debug command (1000, 1001 or 1010) is held, TDO changes on the rising edge of TCK. Each bit is therefore valid half a cycle earlier than with a standard instruction.
- R7: The launch edge follows the instruction already held in the instruction register. The code being shifted in has no effect on it, so the edge changes only after Update-IR.
- R8: TDO output enable is high only in Shift-DR and Shift-IR. It switches on the same edge as TDO data. TDO reads 0 while the enable is low.
- R9: Update-IR with code 1000 sets the CPU reset request, and it stays set through any later instructions. Update-IR with code 1001 clears it. TRST_n low also clears it.
- R10: Update-IR with code 1010 raises the interrupt request for exactly one TCK cycle.
- R11: The external-test, clamp and high-impedance flags are high exactly while codes 0000, 0010 and 0011 are held, respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge of TCK |
| tdi | input | 1 | Serial data in, sampled on the rising edge of TCK |
| tdo | output | 1 | Serial data out, launched on an edge chosen by the instruction |
| tdo_oe | output | 1 | Output enable for TDO |
| cpu_rst_req | output | 1 | Sticky CPU reset request |
| dbg_irq | output | 1 | One-cycle debug interrupt request |
| ext_test | output | 1 | External-test instruction held |
| clamp_hold | output | 1 | Clamp instruction held |
| out_hiz | output | 1 | High-impedance instruction held |

## Verification
The bench builds the block with the default identification parameter. Its bit 0 is 0, so the forcing of that bit to 1 is exercised. The 4-bit instruction width is small enough to load all sixteen codes in turn. Every code is followed by a 40-bit data scan. TDO and its enable are sampled just after each rising edge and again just after each falling edge. These paired samples show which edge launched every bit. The paired samples also cover instruction scans made under a held debug command, which is how the rule that the held instruction alone chooses the edge is tested.

// File: rtl/tap_dual_edge.sv
module tap_dual_edge #(
  parameter logic [31:0] ID_VALUE = 32'h4B3D_7E0A
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  output logic cpu_rst_req,
  output logic dbg_irq,
  output logic ext_test,
  output logic clamp_hold,
  output logic out_hiz
);

  localparam int IR_W = 4;
  localparam int ID_W = 32;
  localparam logic [ID_W-1:0] ID_WORD = {ID_VALUE[ID_W-1:1], 1'b1};

  localparam logic [IR_W-1:0] OP_EXT   = 4'b0000;
  localparam logic [IR_W-1:0] OP_CAPT  = 4'b0001;
  localparam logic [IR_W-1:0] OP_CLAMP = 4'b0010;
  localparam logic [IR_W-1:0] OP_HIZ   = 4'b0011;
  localparam logic [IR_W-1:0] OP_ID    = 4'b0100;
  localparam logic [IR_W-1:0] OP_RSET  = 4'b1000;
  localparam logic [IR_W-1:0] OP_RCLR  = 4'b1001;
  localparam logic [IR_W-1:0] OP_IRQ   = 4'b1010;

  typedef enum logic [3:0] {
    S_RESET, S_IDLE,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_st_t;

  tap_st_t st, st_nx;
  logic [IR_W-1:0] ir, ir_nx, ir_sh, ir_sh_nx;
  logic [ID_W-1:0] dr_sh, dr_nx;
  logic tdo_r, oe_r, tdo_f, oe_f;
  logic id_sel, dbg_ir;

  assign id_sel = (ir == OP_ID);
  assign dbg_ir = (ir == OP_RSET) || (ir == OP_RCLR) || (ir == OP_IRQ);

  function automatic logic in_shift(tap_st_t s);
    return (s == S_SH_DR) || (s == S_SH_IR);
  endfunction

  function automatic logic ser_bit(tap_st_t s, logic [IR_W-1:0] is, logic [ID_W-1:0] d);
    if (s == S_SH_IR) return is[0];
    if (s == S_SH_DR) return d[0];
    return 1'b0;
  endfunction

  always_comb begin
    st_nx = st;
    case (st)
      S_RESET:  st_nx = tms ? S_RESET  : S_IDLE;
      S_IDLE:   st_nx = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: st_nx = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: st_nx = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  st_nx = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: st_nx = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: st_nx = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: st_nx = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: st_nx = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: st_nx = tms ? S_RESET  : S_CAP_IR;
      S_CAP_IR: st_nx = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  st_nx = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: st_nx = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: st_nx = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: st_nx = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: st_nx = tms ? S_SEL_DR : S_IDLE;
      default:  st_nx = S_RESET;
    endcase
  end

  always_comb begin
    ir_sh_nx = ir_sh;
    ir_nx    = ir;
    dr_nx    = dr_sh;
    case (st)
      S_CAP_IR: ir_sh_nx = OP_CAPT;
      S_SH_IR:  ir_sh_nx = {tdi, ir_sh[IR_W-1:1]};
      S_UPD_IR: ir_nx    = ir_sh;
      S_RESET:  ir_nx    = OP_ID;
      S_CAP_DR: dr_nx    = id_sel ? ID_WORD : '0;
      S_SH_DR:  dr_nx    = id_sel ? {tdi, dr_sh[ID_W-1:1]} : {{(ID_W-1){1'b0}}, tdi};
      default: ;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      st          <= S_RESET;
      ir          <= OP_ID;
      ir_sh       <= '0;
      dr_sh       <= '0;
      cpu_rst_req <= 1'b0;
      dbg_irq     <= 1'b0;
      tdo_r       <= 1'b0;
      oe_r        <= 1'b0;
    end else begin
      st      <= st_nx;
      ir      <= ir_nx;
      ir_sh   <= ir_sh_nx;
      dr_sh   <= dr_nx;
      tdo_r   <= ser_bit(st_nx, ir_sh_nx, dr_nx);
      oe_r    <= in_shift(st_nx);
      dbg_irq <= (st == S_UPD_IR) && (ir_sh == OP_IRQ);
      if (st == S_UPD_IR && ir_sh == OP_RSET) cpu_rst_req <= 1'b1;
      else if (st == S_UPD_IR && ir_sh == OP_RCLR) cpu_rst_req <= 1'b0;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_f <= 1'b0;
      oe_f  <= 1'b0;
    end else begin
      tdo_f <= ser_bit(st, ir_sh, dr_sh);
      oe_f  <= in_shift(st);
    end
  end

  assign tdo    = dbg_ir ? tdo_r : tdo_f;
  assign tdo_oe = dbg_ir ? oe_r  : oe_f;

  assign ext_test   = (ir == OP_EXT);
  assign clamp_hold = (ir == OP_CLAMP);
  assign out_hiz    = (ir == OP_HIZ);

  p_capture_ir_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_CAP_IR) |=> (ir_sh == OP_CAPT));

  p_reset_selects_id_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_RESET) |=> (ir == OP_ID));

  p_id_capture_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_CAP_DR && id_sel) |=> (dr_sh == ID_WORD));

  p_oe_in_shift_r8: assert property (@(posedge tck) disable iff (!trst_n)
    oe_r |-> (st == S_SH_DR || st == S_SH_IR));

  p_rst_set_r9: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_UPD_IR && ir_sh == OP_RSET) |=> cpu_rst_req);

  p_rst_clr_r9: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_UPD_IR && ir_sh == OP_RCLR) |=> !cpu_rst_req);

  p_irq_single_r10: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_irq |=> !dbg_irq);

  p_flags_exclusive_r11: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({ext_test, clamp_hold, out_hiz}));

endmodule

// File: tb/tap_dual_edge_bench.sv
module tap_dual_edge_bench;
  localparam logic [31:0] ID_P   = 32'h4B3D_7E0A;
  localparam logic [31:0] ID_EXP = ID_P | 32'h1;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, cpu_rst_req, dbg_irq, ext_test, clamp_hold, out_hiz;
  logic e_tdo, e_oe, l_tdo, l_oe;
  int nchk = 0, nfail = 0;
  bit done = 0;

  tap_dual_edge #(.ID_VALUE(ID_P)) u_tap_dual_edge (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .cpu_rst_req(cpu_rst_req), .dbg_irq(dbg_irq), .ext_test(ext_test),
    .clamp_hold(clamp_hold), .out_hiz(out_hiz));

  always #4 tck = ~tck;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); #1; e_tdo = tdo; e_oe = tdo_oe;
    @(negedge tck); #1; l_tdo = tdo; l_oe = tdo_oe;
  endtask

  task automatic scan(input int n, input logic [63:0] din, input bit dbg,
                      input string req, output logic [63:0] dout);
    logic prev;
    prev = l_tdo;
    dout = '0;
    for (int j = 0; j <= n; j++) begin
      step(j == n, (j == 0) ? 1'b0 : din[j-1]);
      if (j < n) begin
        dout[j] = l_tdo;
        chk({req, " launch edge"}, e_tdo, dbg ? l_tdo : prev);
        chk("R8 early enable", e_oe, (dbg || j > 0) ? 1'b1 : 1'b0);
        chk("R8 late enable", l_oe, 1'b1);
        prev = l_tdo;
      end else begin
        chk("R8 early enable at exit", e_oe, dbg ? 1'b0 : 1'b1);
        chk("R8 late enable at exit", l_oe, 1'b0);
        chk("R8 tdo low when disabled", l_tdo, 1'b0);
      end
    end
  endtask

  task automatic load_ir(input logic [3:0] code, input bit cur_dbg, input bit rst_exp);
    logic [63:0] o;
    step(1, 0); step(1, 0); step(0, 0);
    scan(4, {60'b0, code}, cur_dbg, "R7", o);
    chk("R2 capture-IR pattern", o[3:0], 4'b0001);
    step(1, 0); step(0, 0);
    chk("R10 interrupt pulse", dbg_irq, code == 4'b1010);
    chk("R9 reset request", cpu_rst_req, rst_exp);
    step(0, 0);
    chk("R10 interrupt single cycle", dbg_irq, 1'b0);
  endtask

  task automatic load_dr(input int n, input logic [63:0] din, input bit dbg,
                         output logic [63:0] o);
    step(1, 0); step(0, 0);
    scan(n, din, dbg, dbg ? "R6" : "R5", o);
    step(1, 0); step(0, 0);
  endtask

  task automatic read_id(input string req);
    logic [63:0] o;
    load_dr(32, 64'h0, 1'b0, o);
    chk(req, o[31:0], ID_EXP);
  endtask

  initial begin
    logic [63:0] o, din;
    bit dbg, rst_m;
    #20;
    chk("R9 reset request in reset", cpu_rst_req, 1'b0);
    chk("R8 enable in reset", tdo_oe, 1'b0);
    chk("R10 irq in reset", dbg_irq, 1'b0);
    chk("R11 flags in reset", {ext_test, clamp_hold, out_hiz}, 3'b000);
    @(negedge tck); #1; trst_n = 1'b1;
    step(0, 0);
    read_id("R3 identification after TRST");
    dbg = 0; rst_m = 0;
    for (int c = 0; c < 16; c++) begin
      if (c == 8) rst_m = 1;
      if (c == 9) rst_m = 0;
      load_ir(c[3:0], dbg, rst_m);
      dbg = (c == 8) || (c == 9) || (c == 10);
      chk("R11 external-test flag", ext_test, c == 0);
      chk("R11 clamp flag", clamp_hold, c == 2);
      chk("R11 high-impedance flag", out_hiz, c == 3);
      din = 64'hC3A5_96F0_1E2D_7B48 ^ (64'h9E37_79B9_7F4A_7C15 * (c + 1));
      load_dr(40, din, dbg, o);
      if (c == 4) begin
        chk("R3 identification word", o[31:0], ID_EXP);
        chk("R3 data after word", o[39:32], din[7:0]);
      end else begin
        chk("R4 bypass captures 0", o[0], 1'b0);
        chk((c == 5 || c == 6 || c == 7 || c > 10 && c < 15) ? "R2 unknown code as bypass" : "R4 bypass delay",
            o[39:1], din[38:0]);
      end
    end
    load_ir(4'b1000, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) step(1, 0);
    step(0, 0);
    chk("R9 request survives TMS reset", cpu_rst_req, 1'b1);
    read_id("R1 five TMS ones reach reset");
    @(negedge tck); #2; trst_n = 1'b0; #1;
    chk("R9 TRST clears request", cpu_rst_req, 1'b0);
    chk("R1 asynchronous TRST", tdo_oe, 1'b0);
    #2; trst_n = 1'b1;
    step(0, 0);
    read_id("R1 TRST returns to reset");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule